// File: doc/BRIEF.md
# Effective Address Sequencer

This block produces the final 16-bit memory address that an 8-bit processor's instruction operates on. It takes the addressing mode, the operand bytes that follow the opcode, the two index registers and the program counter. Direct forms (page-zero, full-address, indexed, branch target) are pure arithmetic and complete in one cycle. Pointer forms fetch a two-byte little-endian pointer through a byte-wide read port with a ready handshake before the address is final.

The execution unit pulses `start_i` with all inputs valid. It then waits for `done_o`, which marks `ea_o` as valid. Index values and operands are latched when the request is accepted. A pointer walk therefore does not depend on the inputs holding still.

Top module: `eaddr_gen`

## Requirements
- R1: During and right after reset, `done_o`, `busy_o` and `mem_req_o` are 0 and `ea_o` is 0000.
- R2: Mode codes 0, 1 and 2 are page-zero, page-zero plus X and page-zero plus Y. The result is {00, low operand byte (+index)}. The sum wraps modulo 256 and the high operand byte is ignored.
- R3: Mode codes 3, 4 and 5 are full address, full address plus X and full address plus Y. The 16-bit sum wraps modulo 65536. Unassigned codes 12 to 15 behave as code 3.
- R4: Mode code 11 gives the branch target: `pc_i` plus the low operand byte read as a signed value from -128 to +127.
- R5: For modes 0 to 5 and 11, `done_o` is high in the cycle after the accepting edge, and no memory read is issued.
- R6: Mode code 6 (page-zero X-indexed pointer) first adds X to the low operand byte modulo 256. It reads the pointer low byte at {00,sum} and the high byte at {00,sum+1 mod 256}. The result is {high,low}.
- R7: Mode codes 7 and 8 read the pointer at {00,op} and {00,op+1 mod 256}. Code 7 returns the pointer. Code 8 adds Y to it as a 16-bit sum, carrying into the high byte.
- R8: Mode codes 9 and 10 use the 16-bit operand, plus X (mod 65536) for code 10, as the pointer address. The high byte is read at that address plus one, carrying across a page.
- R9: A read holds `mem_req_o` and `mem_addr_o` steady until `mem_ready_i`. A byte is taken on an edge with both high, the low byte first. `done_o` is high in the cycle after the high byte is taken.
- R10: `start_i` is ignored while `busy_o` is high. Changes to mode, operand, X or Y after acceptance have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request strobe, taken when idle |
| mode_i | input | 4 | Addressing mode code |
| opnd_i | input | 16 | Operand; bits 7:0 first byte, 15:8 second byte |
| idx_x_i | input | 8 | X index |
| idx_y_i | input | 8 | Y index |
| pc_i | input | 16 | Program counter for branch targets |
| mem_req_o | output | 1 | Pointer byte read request |
| mem_addr_o | output | 16 | Pointer byte read address |
| mem_rdata_i | input | 8 | Read data |
| mem_ready_i | input | 1 | Read data valid |
| busy_o | output | 1 | Pointer walk in progress |
| done_o | output | 1 | One-cycle strobe, `ea_o` valid |
| ea_o | output | 16 | Effective address |

## Verification
The bench targets the page-zero wrap at FF for indexed sums and pointer high bytes. A design that carried into page 01 there would read the wrong pointer byte or return 0100-based addresses. It also drives full-address pointers that straddle a page and a Y add that carries into the high byte; dropping either carry shows up as a target 256 bytes off. Negative branch offsets and wrapping full-address sums test the sign extension and the modulo behaviour. Pointer walks with stalled ready and a second start mid-walk catch designs that advance without data or restart, which would give a wrong read order or an extra done.

// File: rtl/ea_pkg.sv
package ea_pkg;

    typedef enum logic [3:0] {
        AM_ZP    = 4'd0,
        AM_ZPX   = 4'd1,
        AM_ZPY   = 4'd2,
        AM_ABS   = 4'd3,
        AM_ABSX  = 4'd4,
        AM_ABSY  = 4'd5,
        AM_ZPXI  = 4'd6,
        AM_ZPI   = 4'd7,
        AM_ZPIY  = 4'd8,
        AM_ABSI  = 4'd9,
        AM_ABSXI = 4'd10,
        AM_REL   = 4'd11
    } am_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LO   = 2'd1,
        ST_HI   = 2'd2
    } st_e;

    function automatic logic is_ptr(input am_e m);
        case (m)
            AM_ZPXI, AM_ZPI, AM_ZPIY, AM_ABSI, AM_ABSXI: return 1'b1;
            default:                                   return 1'b0;
        endcase
    endfunction

    function automatic logic is_zp_ptr(input am_e m);
        case (m)
            AM_ZPXI, AM_ZPI, AM_ZPIY: return 1'b1;
            default:                  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/ea_direct_calc.sv
module ea_direct_calc
    import ea_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int ADDR_W = 2 * DATA_W
) (
    input  am_e               mode,
    input  logic [ADDR_W-1:0] opnd,
    input  logic [DATA_W-1:0] idx_x,
    input  logic [DATA_W-1:0] idx_y,
    input  logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] direct_ea,
    output logic [ADDR_W-1:0] ptr_base
);
    localparam logic [DATA_W-1:0] PAGE0 = '0;

    logic [DATA_W-1:0] op_lo;
    logic [DATA_W-1:0] zp_plus_x;
    logic [DATA_W-1:0] zp_plus_y;
    logic [ADDR_W-1:0] x_wide;
    logic [ADDR_W-1:0] y_wide;
    logic [ADDR_W-1:0] rel_off;

    always_comb begin
        op_lo     = opnd[DATA_W-1:0];
        zp_plus_x = op_lo + idx_x;
        zp_plus_y = op_lo + idx_y;
        x_wide    = {PAGE0, idx_x};
        y_wide    = {PAGE0, idx_y};
        rel_off   = {{DATA_W{op_lo[DATA_W-1]}}, op_lo};

        case (mode)
            AM_ZP:   direct_ea = {PAGE0, op_lo};
            AM_ZPX:  direct_ea = {PAGE0, zp_plus_x};
            AM_ZPY:  direct_ea = {PAGE0, zp_plus_y};
            AM_ABSX: direct_ea = opnd + x_wide;
            AM_ABSY: direct_ea = opnd + y_wide;
            AM_REL:  direct_ea = pc + rel_off;
            default: direct_ea = opnd;
        endcase

        case (mode)
            AM_ZPXI:        ptr_base = {PAGE0, zp_plus_x};
            AM_ZPI, AM_ZPIY: ptr_base = {PAGE0, op_lo};
            AM_ABSXI:       ptr_base = opnd + x_wide;
            default:        ptr_base = opnd;
        endcase
    end
endmodule

// File: rtl/ea_ptr_step.sv
module ea_ptr_step #(
    parameter int DATA_W = 8,
    localparam int ADDR_W = 2 * DATA_W
) (
    input  logic [ADDR_W-1:0] ptr,
    input  logic              zp_wrap,
    output logic [ADDR_W-1:0] ptr_next
);
    logic [DATA_W-1:0] lo_inc;

    always_comb begin
        lo_inc = ptr[DATA_W-1:0] + 1'b1;
        if (zp_wrap)
            ptr_next = {ptr[ADDR_W-1:DATA_W], lo_inc};
        else
            ptr_next = ptr + 1'b1;
    end
endmodule

// File: rtl/ea_final_compose.sv
module ea_final_compose #(
    parameter int DATA_W = 8,
    localparam int ADDR_W = 2 * DATA_W
) (
    input  logic [DATA_W-1:0] lo_byte,
    input  logic [DATA_W-1:0] hi_byte,
    input  logic              add_y,
    input  logic [DATA_W-1:0] idx_y,
    output logic [ADDR_W-1:0] final_ea
);
    localparam logic [DATA_W-1:0] PAGE0 = '0;

    logic [ADDR_W-1:0] y_term;

    always_comb begin
        y_term   = add_y ? {PAGE0, idx_y} : '0;
        final_ea = {hi_byte, lo_byte} + y_term;
    end
endmodule

// File: rtl/eaddr_gen.sv
module eaddr_gen
    import ea_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int ADDR_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [3:0]        mode_i,
    input  logic [ADDR_W-1:0] opnd_i,
    input  logic [DATA_W-1:0] idx_x_i,
    input  logic [DATA_W-1:0] idx_y_i,
    input  logic [ADDR_W-1:0] pc_i,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic              mem_ready_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [ADDR_W-1:0] ea_o
);
    typedef struct packed {
        st_e               st;
        logic [ADDR_W-1:0] ptr;
        logic [DATA_W-1:0] lo;
        logic [DATA_W-1:0] yv;
        logic              zp_ptr;
        logic              add_y;
        logic [ADDR_W-1:0] ea;
        logic              done;
    } regs_t;

    regs_t q, d;

    am_e               mode_e;
    logic              want_ptr;
    logic [ADDR_W-1:0] direct_ea;
    logic [ADDR_W-1:0] ptr_base;
    logic [ADDR_W-1:0] ptr_next;
    logic [ADDR_W-1:0] final_ea;

    assign mode_e   = am_e'(mode_i);
    assign want_ptr = is_ptr(mode_e);

    ea_direct_calc #(.DATA_W(DATA_W)) u_direct (
        .mode      (mode_e),
        .opnd      (opnd_i),
        .idx_x     (idx_x_i),
        .idx_y     (idx_y_i),
        .pc        (pc_i),
        .direct_ea (direct_ea),
        .ptr_base  (ptr_base)
    );

    ea_ptr_step #(.DATA_W(DATA_W)) u_step (
        .ptr      (q.ptr),
        .zp_wrap  (q.zp_ptr),
        .ptr_next (ptr_next)
    );

    ea_final_compose #(.DATA_W(DATA_W)) u_final (
        .lo_byte  (q.lo),
        .hi_byte  (mem_rdata_i),
        .add_y    (q.add_y),
        .idx_y    (q.yv),
        .final_ea (final_ea)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    if (want_ptr) begin
                        d.st     = ST_LO;
                        d.ptr    = ptr_base;
                        d.yv     = idx_y_i;
                        d.zp_ptr = is_zp_ptr(mode_e);
                        d.add_y  = (mode_e == AM_ZPIY);
                    end else begin
                        d.ea   = direct_ea;
                        d.done = 1'b1;
                    end
                end
            end
            ST_LO: begin
                if (mem_ready_i) begin
                    d.lo  = mem_rdata_i;
                    d.ptr = ptr_next;
                    d.st  = ST_HI;
                end
            end
            ST_HI: begin
                if (mem_ready_i) begin
                    d.ea   = final_ea;
                    d.done = 1'b1;
                    d.st   = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign mem_req_o  = (q.st != ST_IDLE);
    assign mem_addr_o = q.ptr;
    assign busy_o     = (q.st != ST_IDLE);
    assign done_o     = q.done;
    assign ea_o       = q.ea;

    AST_READ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o))); // R9
    AST_DIRECT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && !want_ptr) |=> done_o); // R5
    AST_PTR_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && want_ptr) |=> (busy_o && !done_o)); // R9
    AST_DONE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !mem_req_o); // R5
    AST_ZP_PAGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && q.zp_ptr) |-> (mem_addr_o[ADDR_W-1:DATA_W] == '0)); // R6
    AST_ZP_HI_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && q.zp_ptr && $past(mem_req_o && mem_ready_i) && $past(q.st == ST_LO))
        |-> (mem_addr_o[DATA_W-1:0] == $past(mem_addr_o[DATA_W-1:0]) + 1'b1)); // R7
endmodule

// File: tb/eaddr_gen_test.sv
module eaddr_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  mode = '0;
    logic [15:0] opnd = '0;
    logic [7:0]  xr = '0;
    logic [7:0]  yr = '0;
    logic [15:0] pc = '0;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata = '0;
    logic        mem_ready = 1'b0;
    logic        busy;
    logic        done;
    logic [15:0] ea;

    always #5 clk = ~clk;

    eaddr_gen #(.DATA_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode), .opnd_i(opnd),
        .idx_x_i(xr), .idx_y_i(yr), .pc_i(pc), .mem_req_o(mem_req),
        .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata), .mem_ready_i(mem_ready),
        .busy_o(busy), .done_o(done), .ea_o(ea)
    );

    int vectors = 0;
    int miscompares = 0;
    int waits = 0;
    int wcnt = 0;
    string tag = "reset";
    logic [15:0] exp_ea_q[$];
    logic [15:0] exp_rd_q[$];

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    function automatic logic [15:0] ptr_at(input logic [15:0] a0, input logic [15:0] a1);
        return {mem_byte(a1), mem_byte(a0)};
    endfunction

    task automatic check16(input string t, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: got %h expected %h", t, act, exp);
        end
    endtask

    // memory responder: checks read address order, returns bytes after 'waits' cycles
    always @(negedge clk) begin
        if (mem_ready) begin
            mem_ready = 1'b0;
        end else if (rst_n && mem_req) begin
            if (wcnt >= waits) begin
                mem_ready = 1'b1;
                mem_rdata = mem_byte(mem_addr);
                wcnt = 0;
                if (exp_rd_q.size() == 0) check16({tag, " unexpected read"}, mem_addr, 16'hxxxx);
                else check16({tag, " read addr"}, mem_addr, exp_rd_q.pop_front());
            end else begin
                wcnt++;
            end
        end
    end

    // monitor: every done pops one expected address
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_ea_q.size() == 0) check16({tag, " unexpected done"}, ea, 16'hxxxx);
            else check16(tag, ea, exp_ea_q.pop_front());
        end
    end

    task automatic run(input string t, input logic [3:0] m, input logic [15:0] op,
                       input logic [7:0] xv, input logic [7:0] yv, input logic [15:0] pcv,
                       input logic [15:0] exp, input bit ptr, input logic [15:0] a0,
                       input logic [15:0] a1, input bit poke);
        tag = t;
        exp_ea_q.push_back(exp);
        if (ptr) begin
            exp_rd_q.push_back(a0);
            exp_rd_q.push_back(a1);
        end
        @(negedge clk);
        start = 1'b1; mode = m; opnd = op; xr = xv; yr = yv; pc = pcv;
        @(negedge clk);
        // R10: scramble inputs after acceptance
        start = poke; xr = ~xv; yr = ~yv; opnd = ~op; mode = poke ? 4'd0 : m;
        if (!ptr) begin
            check16({t, " R5 done/no-read"}, {14'd0, done, mem_req}, 16'h0002);
            start = 1'b0;
        end else begin
            check16({t, " R9 busy not done"}, {14'd0, busy, done}, 16'h0002);
            while (done !== 1'b1) @(negedge clk);
            start = 1'b0;
            check16({t, " R9 reads consumed"}, 16'(exp_rd_q.size()), 16'd0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check16("R1 reset outputs", {12'd0, done, busy, mem_req, 1'b0}, 16'h0000);
        check16("R1 reset ea", ea, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        check16("R1 after reset", {ea[14:0], done}, 16'h0000);

        run("R2 page zero, high byte ignored", 4'd0, 16'h7742, 8'h00, 8'h00, 16'h0, 16'h0042, 0, 0, 0, 0);
        run("R2 page zero X wraps", 4'd1, 16'h00F0, 8'h20, 8'h00, 16'h0, 16'h0010, 0, 0, 0, 0);
        run("R2 page zero Y", 4'd2, 16'h1201, 8'h00, 8'h03, 16'h0, 16'h0004, 0, 0, 0, 0);
        run("R3 absolute", 4'd3, 16'hD010, 8'h11, 8'h22, 16'h0, 16'hD010, 0, 0, 0, 0);
        run("R3 absolute X", 4'd4, 16'hC001, 8'h02, 8'h00, 16'h0, 16'hC003, 0, 0, 0, 0);
        run("R3 absolute X wraps", 4'd4, 16'hFFFF, 8'h02, 8'h00, 16'h0, 16'h0001, 0, 0, 0, 0);
        run("R3 absolute Y carry", 4'd5, 16'h12F0, 8'h00, 8'h20, 16'h0, 16'h1310, 0, 0, 0, 0);
        run("R3 unassigned code", 4'd13, 16'h1234, 8'h55, 8'h66, 16'h0, 16'h1234, 0, 0, 0, 0);
        run("R4 branch forward", 4'd11, 16'h002D, 8'h00, 8'h00, 16'hC100, 16'hC12D, 0, 0, 0, 0);
        run("R4 branch -128", 4'd11, 16'h0080, 8'h00, 8'h00, 16'hC100, 16'hC080, 0, 0, 0, 0);
        run("R4 branch wraps", 4'd11, 16'h00F0, 8'h00, 8'h00, 16'h0010, 16'h0000, 0, 0, 0, 0);

        for (int pass = 0; pass < 2; pass++) begin
            waits = pass * 2;
            run("R6 X pointer", 4'd6, 16'h0015, 8'h02, 8'h00, 16'h0,
                ptr_at(16'h0017, 16'h0018), 1, 16'h0017, 16'h0018, 0);
            run("R6 X pointer page wrap", 4'd6, 16'h99FE, 8'h01, 8'h00, 16'h0,
                ptr_at(16'h00FF, 16'h0000), 1, 16'h00FF, 16'h0000, 0);
            run("R7 plain pointer", 4'd7, 16'h0015, 8'h40, 8'h40, 16'h0,
                ptr_at(16'h0015, 16'h0016), 1, 16'h0015, 16'h0016, 0);
            run("R7 plain pointer wrap", 4'd7, 16'h00FF, 8'h00, 8'h00, 16'h0,
                ptr_at(16'h00FF, 16'h0000), 1, 16'h00FF, 16'h0000, 0);
            run("R7 pointer plus Y", 4'd8, 16'h002A, 8'h00, 8'h03, 16'h0,
                ptr_at(16'h002A, 16'h002B) + 16'h0003, 1, 16'h002A, 16'h002B, 0);
            run("R7 pointer plus Y carry", 4'd8, 16'h002A, 8'h00, 8'hFF, 16'h0,
                ptr_at(16'h002A, 16'h002B) + 16'h00FF, 1, 16'h002A, 16'h002B, 0);
            run("R8 absolute pointer page cross", 4'd9, 16'hA0FF, 8'h00, 8'h00, 16'h0,
                ptr_at(16'hA0FF, 16'hA100), 1, 16'hA0FF, 16'hA100, 0);
            run("R8 absolute X pointer", 4'd10, 16'hE015, 8'h06, 8'h00, 16'h0,
                ptr_at(16'hE01B, 16'hE01C), 1, 16'hE01B, 16'hE01C, 0);
            run("R8 absolute X pointer wrap", 4'd10, 16'hFFFF, 8'h01, 8'h00, 16'h0,
                ptr_at(16'h0000, 16'h0001), 1, 16'h0000, 16'h0001, 0);
        end

        waits = 1;
        run("R10 start ignored while busy", 4'd8, 16'h0030, 8'h00, 8'h10, 16'h0,
            ptr_at(16'h0030, 16'h0031) + 16'h0010, 1, 16'h0030, 16'h0031, 1);
        repeat (3) @(negedge clk);
        check16("R10 no extra result", 16'(exp_ea_q.size()), 16'd0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: got hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule